// File: doc/BRIEF.md
# Two-Accumulator Nibble-Literal Processor Core

This block is a small processor core that completes one 6-bit instruction in every clock cycle. It keeps an 8-bit program counter and two 8-bit accumulators, A and B. It fetches from an external read-only program store through a combinational address/instruction pair. It reaches an external byte-wide data memory through a port whose read is combinational, so a load completes within its own cycle. Debug outputs show the program counter and both accumulators at all times.

The only arithmetic is a wrapping add. The only logic operations are NAND and a bitwise XNOR, which serves as an equality test. Constants are built into accumulator A one 4-bit half at a time, using two literal forms that keep the other half. Memory accesses and the conditional jump take their address from accumulator B. No instruction writes accumulator B, so it holds its reset value.

The core is meant to sit next to a small program ROM and a register-file-style data RAM. The surrounding logic provides the clock and an active-high synchronous reset.

Top module: `nibble_acc_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the program counter, accumulator A and accumulator B are all set to zero.
- R2: Opcode 6'b100000 sets A to (A + B) mod 256. No carry is kept.
- R3: Opcode 6'b100001 sets A to the bitwise NAND of A and B.
- R4: Opcode 6'b100010 sets A to the bitwise XNOR of A and B.
- R5: Opcode 6'b110000 loads the program counter with B when A is nonzero. When A is zero it increments the program counter. A is unchanged in both cases.
- R6: During a cycle whose opcode is 6'b111110, `memWrEn` is 1 and `memWrData` equals A, so the byte is written at address B on the next edge. `memWrEn` is 0 for every other opcode.
- R7: Opcode 6'b111111 sets A to `memRdData`, which is read at address B in the same cycle.
- R8: Opcodes of the form 2'b00 followed by a 4-bit k set A[3:0] to k and keep A[7:4].
- R9: Opcodes of the form 2'b01 followed by a 4-bit k set A[7:4] to k and keep A[3:0].
- R10: Every instruction except a taken jump adds one to the program counter, wrapping from 255 to 0.
- R11: Any opcode not listed in R2 to R9 (for example 6'b100011, 6'b101010, 6'b111000) leaves A and B unchanged and does not write memory.
- R12: Accumulator B is written by no instruction. `memAddr` always equals B and `progAddr` always equals the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| progAddr | output | 8 | Program store address (program counter) |
| progInstr | input | 6 | Instruction read from the program store |
| memAddr | output | 8 | Data memory address (accumulator B) |
| memWrData | output | 8 | Data memory write byte (accumulator A) |
| memWrEn | output | 1 | Data memory write strobe for this cycle |
| memRdData | input | 8 | Data memory read byte at `memAddr`, combinational |
| dbgPc | output | 8 | Current program counter |
| dbgAccA | output | 8 | Current accumulator A |
| dbgAccB | output | 8 | Current accumulator B |

## Verification
All state is architectural and visible on the debug outputs, so a wrong accumulator or program counter appears on the ports one edge after the instruction that produced it. A wrong program counter also shows at once on `progAddr` and changes which instruction runs next. A decode fault that raises the write strobe on the wrong opcode shows combinationally in the same cycle, and it shows again later as a corrupted byte when that address is loaded back into A. Because B never changes, any fault that disturbs B shows at once on both `memAddr` and `dbgAccB`.

// File: rtl/nac_pkg.sv
package nac_pkg;
  localparam int DATA_W  = 8;
  localparam int INSTR_W = 6;
  localparam int LIT_W   = INSTR_W - 2;
  localparam int HALF_W  = DATA_W / 2;

  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [INSTR_W-1:0] instr_t;
  typedef logic [LIT_W-1:0]   lit_t;

  // Exact opcodes; the two literal forms are matched by their top two bits.
  localparam instr_t OP_ADD   = 6'b100000;
  localparam instr_t OP_NAND  = 6'b100001;
  localparam instr_t OP_XNOR  = 6'b100010;
  localparam instr_t OP_JUMP  = 6'b110000;
  localparam instr_t OP_STORE = 6'b111110;
  localparam instr_t OP_LOAD  = 6'b111111;
  localparam logic [1:0] PFX_LITLO = 2'b00;
  localparam logic [1:0] PFX_LITHI = 2'b01;

  typedef enum logic [2:0] {
    SRC_ADD,
    SRC_NAND,
    SRC_XNOR,
    SRC_LOAD,
    SRC_LITLO,
    SRC_LITHI
  } accSrc_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    accWr;
    accSrc_e accSrc;
    logic    pcLoad;
    logic    memWr;
  } ctrl_t;
endpackage

// File: rtl/nac_ctrl.sv
module nac_ctrl
  import nac_pkg::*;
(
  input  instr_t instr,
  input  logic   accAZero,
  output ctrl_t  ctrl,
  output lit_t   litVal
);
  logic [1:0] prefix;

  assign prefix = instr[INSTR_W-1 -: 2];
  assign litVal = instr[LIT_W-1:0];

  always_comb begin
    ctrl.accWr  = 1'b0;
    ctrl.accSrc = SRC_ADD;
    ctrl.pcLoad = 1'b0;
    ctrl.memWr  = 1'b0;
    if (prefix == PFX_LITLO) begin
      ctrl.accWr  = 1'b1;
      ctrl.accSrc = SRC_LITLO;
    end else if (prefix == PFX_LITHI) begin
      ctrl.accWr  = 1'b1;
      ctrl.accSrc = SRC_LITHI;
    end else begin
      unique case (instr)
        OP_ADD: begin
          ctrl.accWr  = 1'b1;
          ctrl.accSrc = SRC_ADD;
        end
        OP_NAND: begin
          ctrl.accWr  = 1'b1;
          ctrl.accSrc = SRC_NAND;
        end
        OP_XNOR: begin
          ctrl.accWr  = 1'b1;
          ctrl.accSrc = SRC_XNOR;
        end
        OP_LOAD: begin
          ctrl.accWr  = 1'b1;
          ctrl.accSrc = SRC_LOAD;
        end
        OP_STORE: ctrl.memWr  = 1'b1;
        OP_JUMP:  ctrl.pcLoad = !accAZero;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nac_dpath.sv
module nac_dpath
  import nac_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  input  lit_t  litVal,
  input  word_t memRdData,
  output word_t pc,
  output word_t accA,
  output word_t accB,
  output logic  accAZero
);
  word_t aluOut;
  word_t pcNext;

  assign accAZero = (accA == '0);

  always_comb begin
    unique case (ctrl.accSrc)
      SRC_ADD:   aluOut = accA + accB;
      SRC_NAND:  aluOut = ~(accA & accB);
      SRC_XNOR:  aluOut = ~(accA ^ accB);
      SRC_LOAD:  aluOut = memRdData;
      SRC_LITLO: aluOut = {accA[DATA_W-1:HALF_W], litVal};
      SRC_LITHI: aluOut = {litVal, accA[HALF_W-1:0]};
      default:   aluOut = accA;
    endcase
  end

  assign pcNext = ctrl.pcLoad ? accB : pc + word_t'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      accA <= '0;
    end else begin
      pc <= pcNext;
      if (ctrl.accWr) accA <= aluOut;
    end
  end

  // No opcode writes B; it only holds its reset value.
  always_ff @(posedge clk) begin
    if (rst) accB <= '0;
  end
endmodule

// File: rtl/nibble_acc_core.sv
module nibble_acc_core
  import nac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] progAddr,
  input  logic [5:0] progInstr,
  output logic [7:0] memAddr,
  output logic [7:0] memWrData,
  output logic       memWrEn,
  input  logic [7:0] memRdData,
  output logic [7:0] dbgPc,
  output logic [7:0] dbgAccA,
  output logic [7:0] dbgAccB
);
  ctrl_t ctrl;
  lit_t  litVal;
  word_t pc;
  word_t accA;
  word_t accB;
  logic  accAZero;

  nac_ctrl ctrl_i (
    .instr    (progInstr),
    .accAZero (accAZero),
    .ctrl     (ctrl),
    .litVal   (litVal)
  );

  nac_dpath dpath_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .litVal    (litVal),
    .memRdData (memRdData),
    .pc        (pc),
    .accA      (accA),
    .accB      (accB),
    .accAZero  (accAZero)
  );

  assign progAddr  = pc;
  assign memAddr   = accB;
  assign memWrData = accA;
  assign memWrEn   = ctrl.memWr;
  assign dbgPc     = pc;
  assign dbgAccA   = accA;
  assign dbgAccB   = accB;
endmodule

// File: rtl/nac_checker.sv
module nac_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] progAddr,
  input logic [5:0] progInstr,
  input logic [7:0] memAddr,
  input logic [7:0] memWrData,
  input logic       memWrEn,
  input logic [7:0] memRdData,
  input logic [7:0] dbgPc,
  input logic [7:0] dbgAccA,
  input logic [7:0] dbgAccB
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dbgPc == 8'd0 && dbgAccA == 8'd0 && dbgAccB == 8'd0));

  p_add_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    progInstr == 6'b100000 |=> dbgAccA == 8'($past(dbgAccA) + $past(dbgAccB)));

  p_jump_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (progInstr == 6'b110000 && dbgAccA != 8'd0) |=> dbgPc == $past(dbgAccB));

  p_store_port_r6: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> (progInstr == 6'b111110 && memWrData == dbgAccA));

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    progInstr == 6'b111111 |=> dbgAccA == $past(memRdData));

  p_lit_low_r8: assert property (@(posedge clk) disable iff (rst)
    progInstr[5:4] == 2'b00 |=>
      (dbgAccA[3:0] == $past(progInstr[3:0]) && dbgAccA[7:4] == $past(dbgAccA[7:4])));

  p_lit_high_r9: assert property (@(posedge clk) disable iff (rst)
    progInstr[5:4] == 2'b01 |=>
      (dbgAccA[7:4] == $past(progInstr[3:0]) && dbgAccA[3:0] == $past(dbgAccA[3:0])));

  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    progInstr != 6'b110000 |=> dbgPc == 8'($past(dbgPc) + 8'd1));

  p_b_stable_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(dbgAccB));

  p_addr_ports_r12: assert property (@(posedge clk) disable iff (rst)
    (memAddr == dbgAccB && progAddr == dbgPc));
endmodule

bind nibble_acc_core nac_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .progAddr  (progAddr),
  .progInstr (progInstr),
  .memAddr   (memAddr),
  .memWrData (memWrData),
  .memWrEn   (memWrEn),
  .memRdData (memRdData),
  .dbgPc     (dbgPc),
  .dbgAccA   (dbgAccA),
  .dbgAccB   (dbgAccB)
);

// File: tb/nibble_acc_core_tb_top.sv
`timescale 1ns/1ps
module nibble_acc_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] progAddr;
  logic [5:0] progInstr;
  logic [7:0] memAddr;
  logic [7:0] memWrData;
  logic       memWrEn;
  logic [7:0] memRdData;
  logic [7:0] dbgPc;
  logic [7:0] dbgAccA;
  logic [7:0] dbgAccB;

  logic [5:0] prog [256];
  logic [7:0] dmem [256];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [5:0] NOP = 6'b100011;

  always #10 clk = ~clk;

  assign progInstr = prog[progAddr];
  assign memRdData = dmem[memAddr];
  always @(posedge clk) if (memWrEn) dmem[memAddr] <= memWrData;

  nibble_acc_core dut_i (
    .clk(clk), .rst(rst), .progAddr(progAddr), .progInstr(progInstr),
    .memAddr(memAddr), .memWrData(memWrData), .memWrEn(memWrEn),
    .memRdData(memRdData), .dbgPc(dbgPc), .dbgAccA(dbgAccA), .dbgAccB(dbgAccB)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fillNop();
    for (int i = 0; i < 256; i++) prog[i] = NOP;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    fillNop();
    doReset();
    check("R1 pc", dbgPc, 8'h00);
    check("R1 accA", dbgAccA, 8'h00);
    check("R1 accB", dbgAccB, 8'h00);
    check("R12 memAddr", memAddr, 8'h00);
  endtask

  task automatic testLiterals();
    fillNop();
    prog[0] = 6'b001010;
    prog[1] = 6'b010011;
    prog[2] = 6'b000101;
    doReset();
    step(1);
    check("R8 low nibble", dbgAccA, 8'h0A);
    step(1);
    check("R9 high nibble", dbgAccA, 8'h3A);
    step(1);
    check("R8 keeps high", dbgAccA, 8'h35);
    check("R10 pc", dbgPc, 8'h03);
  endtask

  task automatic testAlu();
    fillNop();
    prog[0] = 6'b001010;
    prog[1] = 6'b010011;
    prog[2] = 6'b100010;
    prog[3] = 6'b100000;
    prog[4] = 6'b100001;
    prog[5] = 6'b000000;
    prog[6] = 6'b100010;
    doReset();
    step(3);
    check("R4 xnor", dbgAccA, 8'hC5);
    step(1);
    check("R2 add", dbgAccA, 8'hC5);
    step(1);
    check("R3 nand", dbgAccA, 8'hFF);
    step(2);
    check("R4 xnor second", dbgAccA, 8'h0F);
    check("R12 accB", dbgAccB, 8'h00);
  endtask

  task automatic testMemory();
    fillNop();
    dmem[0] = 8'h00;
    prog[0] = 6'b001100;
    prog[1] = 6'b010101;
    prog[2] = 6'b111110;
    prog[3] = 6'b000000;
    prog[4] = 6'b010000;
    prog[5] = 6'b111111;
    doReset();
    check("R6 no write on literal", memWrEn, 1'b0);
    step(2);
    check("R6 write strobe", memWrEn, 1'b1);
    check("R6 write data", memWrData, 8'h5C);
    check("R12 write addr", memAddr, 8'h00);
    step(1);
    check("R6 stored byte", dmem[0], 8'h5C);
    check("R6 strobe drops", memWrEn, 1'b0);
    step(2);
    check("R7 cleared before load", dbgAccA, 8'h00);
    step(1);
    check("R7 load", dbgAccA, 8'h5C);
  endtask

  task automatic testJump();
    fillNop();
    prog[0] = 6'b000001;
    prog[1] = 6'b110000;
    doReset();
    step(2);
    check("R5 taken to B", dbgPc, 8'h00);
    check("R5 accA kept", dbgAccA, 8'h01);
    fillNop();
    prog[0] = 6'b000000;
    prog[1] = 6'b110000;
    doReset();
    step(2);
    check("R5 not taken", dbgPc, 8'h02);
  endtask

  task automatic testUndefined();
    fillNop();
    prog[0] = 6'b000111;
    prog[1] = 6'b011001;
    prog[2] = 6'b101010;
    prog[3] = 6'b111000;
    prog[4] = 6'b100011;
    doReset();
    step(2);
    check("R11 strobe on 101010", memWrEn, 1'b0);
    step(1);
    check("R11 strobe on 111000", memWrEn, 1'b0);
    step(2);
    check("R11 accA", dbgAccA, 8'h97);
    check("R11 accB", dbgAccB, 8'h00);
    check("R10 pc after no-ops", dbgPc, 8'h05);
  endtask

  task automatic testWrap();
    fillNop();
    doReset();
    step(255);
    check("R10 pc at 255", dbgPc, 8'hFF);
    check("R12 progAddr", progAddr, 8'hFF);
    step(1);
    check("R10 wrap", dbgPc, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
    testReset();
    testLiterals();
    testAlu();
    testMemory();
    testJump();
    testUndefined();
    testWrap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule